// File: doc/BRIEF.md
# Tick-Timed Line Deglitcher

This block conditions an asynchronous single-wire bus input, such as an open-drain consumer-electronics control line, before a protocol engine samples it. The raw line first passes through a two-flop synchronizer. A new level is then accepted only after it has stayed unchanged for a programmable number of ticks. Until then the filtered output keeps its previous level. The output resets to high, which is the idle level of an open-drain bus. One-cycle strobes mark each accepted rising and falling transition.

The tick is chosen from four periodic pulses, each made by a small prescaler chain. Code 0 is a fast tick that stands for three crystal periods. Code 1 is the microsecond tick. Codes 2 and 3 each divide the previous tick by a decade factor. The required stable time is the 3-bit delay value multiplied by three ticks. The usual setting is the microsecond tick with a delay of 7. A delay of zero turns the filter off, so the output follows the synchronized line directly.

Top module: `tick_glitch_filter`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, the filtered level is 1 and both strobes are 0.
- R2: With delay 0, a change on the raw line that is set up before a rising clock edge appears on the filtered level after exactly three rising edges, and not after two.
- R3: With delay D > 0, tick period P and T = 3·D, a level held on the raw line for at most (T−1)·P clock cycles never reaches the output and produces no strobe.
- R4: With delay D > 0, a level held for (T+2)·P+6 cycles or longer appears on the output, with exactly one strobe of the matching direction.
- R5: Tick select code 0 gives a tick every FAST_DIV clocks. Code 1 gives one every US_DIV clocks, code 2 every US_DIV·DECADE clocks and code 3 every US_DIV·DECADE² clocks. With delay D > 0, the output does not change within (T−1)·P cycles of a raw change.
- R6: The rise strobe is high for exactly one cycle: the first cycle in which the filtered level reads 1 after reading 0.
- R7: The fall strobe is high for exactly one cycle: the first cycle in which the filtered level reads 0 after reading 1. It is never high together with the rise strobe.
- R8: Any return of the synchronized line to the current output level restarts the count. Two rejectable pulses of the new level, separated by a 3-cycle return to the old level, do not reach the output even though their total length exceeds T·P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_raw | input | 1 | Asynchronous raw line |
| tick_sel | input | 2 | Tick source code (0 fast, 1 one-microsecond, 2 ten-microsecond, 3 hundred-microsecond) |
| delay | input | 3 | Delay value; stable time is 3·delay ticks; 0 bypasses the filter |
| line_clean | output | 1 | Filtered line level, resets high |
| rise_stb | output | 1 | One-cycle strobe on an accepted 0→1 change |
| fall_stb | output | 1 | One-cycle strobe on an accepted 1→0 change |

## Verification
The bench builds the block with FAST_DIV=2, US_DIV=3 and DECADE=2, so the four tick periods are 2, 3, 6 and 12 clocks. At these periods, the longest stable time (delay 7 on the slowest tick) is only 252 cycles. This makes it affordable to sweep every tick code against every nonzero delay. Each combination is tested with a rejected pulse, an accepted change in both directions and a split pulse that must restart the count. The bypass path is checked at its exact three-edge latency.

// File: rtl/tgf_pkg.sv
package tgf_pkg;

    localparam int NUM_TICKS   = 4;
    localparam int DLY_W       = 3;
    localparam int FILTER_MULT = 3;
    localparam int MAX_TICKS   = ((1 << DLY_W) - 1) * FILTER_MULT;
    localparam int CNT_W       = $clog2(MAX_TICKS + 1);

    typedef enum logic [1:0] {
        TICK_FAST  = 2'd0,
        TICK_1US   = 2'd1,
        TICK_10US  = 2'd2,
        TICK_100US = 2'd3
    } tick_code_e;

    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } line_state_t;

    function automatic logic [CNT_W-1:0] need_ticks(input logic [DLY_W-1:0] d);
        return CNT_W'(d) * CNT_W'(FILTER_MULT);
    endfunction

    function automatic int cnt_width(input int limit);
        return (limit > 1) ? $clog2(limit) : 1;
    endfunction

endpackage

// File: rtl/tgf_tick_gen.sv
module tgf_tick_gen
    import tgf_pkg::*;
#(
    parameter int FAST_DIV = 3,
    parameter int US_DIV   = 24,
    parameter int DECADE   = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] tick_sel,
    output logic       tick_o
);

    localparam int FW = cnt_width(FAST_DIV);
    localparam int UW = cnt_width(US_DIV);
    localparam int DW = cnt_width(DECADE);

    logic [NUM_TICKS-1:0] ticks;
    logic [FW-1:0]        fast_cnt;
    logic [UW-1:0]        us_cnt;

    // fast tick: stands in for three crystal periods
    always_ff @(posedge clk) begin
        if (rst)
            fast_cnt <= '0;
        else if (fast_cnt == FW'(FAST_DIV - 1))
            fast_cnt <= '0;
        else
            fast_cnt <= fast_cnt + 1'b1;
    end
    assign ticks[0] = (fast_cnt == FW'(FAST_DIV - 1));

    // microsecond tick
    always_ff @(posedge clk) begin
        if (rst)
            us_cnt <= '0;
        else if (us_cnt == UW'(US_DIV - 1))
            us_cnt <= '0;
        else
            us_cnt <= us_cnt + 1'b1;
    end
    assign ticks[1] = (us_cnt == UW'(US_DIV - 1));

    // decade dividers chained from the microsecond tick
    for (genvar g = 2; g < NUM_TICKS; g++) begin : g_decade
        logic [DW-1:0] dcnt;
        always_ff @(posedge clk) begin
            if (rst)
                dcnt <= '0;
            else if (ticks[g-1])
                dcnt <= (dcnt == DW'(DECADE - 1)) ? '0 : dcnt + 1'b1;
        end
        assign ticks[g] = ticks[g-1] && (dcnt == DW'(DECADE - 1));
    end

    assign tick_o = ticks[tick_sel];

endmodule

// File: rtl/tgf_sync.sv
module tgf_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst)
            chain <= {STAGES{RST_VAL}};
        else
            chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/tgf_stable_filter.sv
module tgf_stable_filter
    import tgf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_i,
    input  logic             tick_i,
    input  logic [DLY_W-1:0] delay_i,
    output logic             level_o
);

    logic             cand;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0] target;

    assign cnt_nxt = cnt + 1'b1;
    assign target  = need_ticks(delay_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            cand    <= 1'b1;
            cnt     <= '0;
            level_o <= 1'b1;
        end else begin
            cand <= sync_i;
            if (delay_i == '0) begin
                level_o <= sync_i;
                cnt     <= '0;
            end else if (sync_i != cand || sync_i == level_o) begin
                cnt <= '0;
            end else if (tick_i) begin
                if (cnt_nxt >= target) begin
                    level_o <= cand;
                    cnt     <= '0;
                end else begin
                    cnt <= cnt_nxt;
                end
            end
        end
    end

endmodule

// File: rtl/tgf_edge_det.sv
module tgf_edge_det
    import tgf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        level_i,
    output line_state_t state_o
);

    logic prev;

    always_ff @(posedge clk) begin
        if (rst)
            prev <= 1'b1;
        else
            prev <= level_i;
    end

    assign state_o.level = level_i;
    assign state_o.rise  = level_i & ~prev;
    assign state_o.fall  = ~level_i & prev;

endmodule

// File: rtl/tick_glitch_filter.sv
module tick_glitch_filter
    import tgf_pkg::*;
#(
    parameter int FAST_DIV = 3,
    parameter int US_DIV   = 24,
    parameter int DECADE   = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       line_raw,
    input  logic [1:0] tick_sel,
    input  logic [2:0] delay,
    output logic       line_clean,
    output logic       rise_stb,
    output logic       fall_stb
);

    logic        sync_lvl;
    logic        tick_pick;
    logic        filt_lvl;
    line_state_t st;

    tgf_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (line_raw),
        .q   (sync_lvl)
    );

    tgf_tick_gen #(.FAST_DIV(FAST_DIV), .US_DIV(US_DIV), .DECADE(DECADE)) u_tick (
        .clk      (clk),
        .rst      (rst),
        .tick_sel (tick_sel),
        .tick_o   (tick_pick)
    );

    tgf_stable_filter u_filt (
        .clk     (clk),
        .rst     (rst),
        .sync_i  (sync_lvl),
        .tick_i  (tick_pick),
        .delay_i (delay),
        .level_o (filt_lvl)
    );

    tgf_edge_det u_edge (
        .clk     (clk),
        .rst     (rst),
        .level_i (filt_lvl),
        .state_o (st)
    );

    assign line_clean = st.level;
    assign rise_stb   = st.rise;
    assign fall_stb   = st.fall;

endmodule

// File: rtl/tick_glitch_filter_chk.sv
module tick_glitch_filter_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] delay,
    input logic       sync_lvl,
    input logic       tick_pick,
    input logic       line_clean,
    input logic       rise_stb,
    input logic       fall_stb
);

    a_r1_reset_level: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (line_clean && !rise_stb && !fall_stb));

    a_r2_bypass_follows: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(delay) == 3'd0) |-> (line_clean == $past(sync_lvl)));

    a_r3_change_on_tick: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(delay) != 3'd0 && line_clean != $past(line_clean))
        |-> $past(tick_pick));

    a_r4_takes_sync_level: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && line_clean != $past(line_clean)) |-> (line_clean == $past(sync_lvl)));

    a_r6_rise_marks_edge: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && rise_stb) |-> (line_clean && !$past(line_clean)));

    a_r7_fall_marks_edge: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && fall_stb) |-> (!line_clean && $past(line_clean)));

    a_r7_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(rise_stb && fall_stb));

endmodule

bind tick_glitch_filter tick_glitch_filter_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .delay      (delay),
    .sync_lvl   (sync_lvl),
    .tick_pick  (tick_pick),
    .line_clean (line_clean),
    .rise_stb   (rise_stb),
    .fall_stb   (fall_stb)
);

// File: tb/sim_tick_glitch_filter.sv
module sim_tick_glitch_filter;

    localparam int CLK_NS   = 10;
    localparam int FAST_DIV = 2;
    localparam int US_DIV   = 3;
    localparam int DECADE   = 2;
    localparam int WATCHDOG = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line_raw = 1'b1;
    logic [1:0] tick_sel = 2'd0;
    logic [2:0] delay = 3'd0;
    logic       line_clean, rise_stb, fall_stb;

    int checks = 0;
    int fails = 0;
    int n_rise = 0;
    int n_fall = 0;
    bit done = 0;

    always #(CLK_NS/2) clk = ~clk;

    tick_glitch_filter #(.FAST_DIV(FAST_DIV), .US_DIV(US_DIV), .DECADE(DECADE)) u0 (
        .clk(clk), .rst(rst), .line_raw(line_raw), .tick_sel(tick_sel),
        .delay(delay), .line_clean(line_clean), .rise_stb(rise_stb), .fall_stb(fall_stb)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (rise_stb) n_rise++;
            if (fall_stb) n_fall++;
        end
    end

    function automatic int period(input int sel);
        case (sel)
            0: return FAST_DIV;
            1: return US_DIV;
            2: return US_DIV * DECADE;
            default: return US_DIV * DECADE * DECADE;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        wait_cyc(WATCHDOG);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
        finish_run();
    end

    initial begin
        logic cur;
        wait_cyc(3);
        // R1: reset state
        check(line_clean == 1'b1, "R1 level", int'(line_clean), 1);
        check(!rise_stb && !fall_stb, "R1 strobes", int'(rise_stb | fall_stb), 0);
        rst = 1'b0;
        @(negedge clk);
        check(line_clean == 1'b1, "R1 level after release", int'(line_clean), 1);

        // R2: bypass latency, R6/R7 strobes
        wait_cyc(4);
        line_raw = 1'b0;
        wait_cyc(2);
        check(line_clean == 1'b1, "R2 not after two edges", int'(line_clean), 1);
        @(negedge clk);
        check(line_clean == 1'b0, "R2 after three edges", int'(line_clean), 0);
        check(fall_stb == 1'b1, "R7 fall strobe", int'(fall_stb), 1);
        @(negedge clk);
        check(fall_stb == 1'b0, "R7 one cycle", int'(fall_stb), 0);
        line_raw = 1'b1;
        wait_cyc(3);
        check(line_clean == 1'b1, "R2 rise after three edges", int'(line_clean), 1);
        check(rise_stb == 1'b1, "R6 rise strobe", int'(rise_stb), 1);
        @(negedge clk);
        check(rise_stb == 1'b0, "R6 one cycle", int'(rise_stb), 0);

        cur = 1'b1;
        for (int s = 0; s < 4; s++) begin
            for (int d = 1; d < 8; d++) begin
                int p, t, r0, f0;
                p = period(s);
                t = 3 * d;
                tick_sel = 2'(s);
                delay = 3'(d);
                wait_cyc(2 * p + 4);

                // R3: rejected pulse
                r0 = n_rise; f0 = n_fall;
                line_raw = ~cur;
                wait_cyc((t - 1) * p);
                line_raw = cur;
                wait_cyc((t + 2) * p + 6);
                check(line_clean == cur, "R3 pulse rejected", int'(line_clean), int'(cur));
                check(n_rise == r0 && n_fall == f0, "R3 no strobe",
                      (n_rise - r0) + (n_fall - f0), 0);

                // R8: split pulse restarts the count
                if (d >= 2) begin
                    line_raw = ~cur;
                    wait_cyc((t - 1) * p);
                    line_raw = cur;
                    wait_cyc(3);
                    line_raw = ~cur;
                    wait_cyc((t - 1) * p);
                    line_raw = cur;
                    wait_cyc((t + 2) * p + 6);
                    check(line_clean == cur, "R8 restart on return", int'(line_clean), int'(cur));
                end

                // R5 minimum latency, R4 acceptance, R6/R7 counts
                r0 = n_rise; f0 = n_fall;
                line_raw = ~cur;
                wait_cyc((t - 1) * p);
                check(line_clean == cur, "R5 not before stable time", int'(line_clean), int'(cur));
                wait_cyc(3 * p + 6);
                check(line_clean == ~cur, "R4 level accepted", int'(line_clean), int'(~cur));
                if (cur) begin
                    check(n_fall - f0 == 1 && n_rise == r0, "R7 single fall strobe", n_fall - f0, 1);
                end else begin
                    check(n_rise - r0 == 1 && n_fall == f0, "R6 single rise strobe", n_rise - r0, 1);
                end
                cur = ~cur;
            end
        end
        finish_run();
    end

endmodule